// File: doc/BRIEF.md
# Serial Equalizer Coefficient and Status Port

This block is the slave end of a four-signal serial link through which a host microcontroller configures a multichannel equalizer. The host signals are an enable strobe, a bit clock, a two-bit control code and one bidirectional data line. Every transfer carries one byte. The control code is captured when the enable strobe rises, and it picks one of four actions. A mode byte sets the operating mode and the kind of data the next read returns. An address byte selects a channel and tap. A coefficient byte is written into the selected slot of a channel-by-tap coefficient store. A read shifts out either the selected coefficient or a tape-speed status byte. The tape-speed byte arrives on an input port.

All host pins are brought into the system clock domain through synchronizers, and edges are detected in that domain. The host must therefore hold each level for several system clocks. The coefficient store also has a combinational read port for the equalizer datapath, which reads any channel and tap at any time. A transfer counts only when exactly eight bits have arrived by the time the enable strobe falls. The block always returns to coefficient readback after each read, so a status read must be set up again before each use.

Top module: `eq_coef_serial_port`

## Requirements
- R1: After reset the data line output enable is low, the operating mode output is 00, the readback kind is coefficient, the selected address is channel 0 tap 0, and every stored coefficient is zero.
- R2: A transfer begins on a rising edge of the enable strobe, which latches the control code: 11 mode byte, 10 address byte, 00 coefficient write, 01 read. Data bits are taken on rising edges of the bit clock while the enable strobe is high, least significant bit first. The transfer ends on the falling edge of the enable strobe.
- R3: In a mode byte, bits 1:0 drive the operating mode output and bits 3:2 set the readback kind, where 01 means speed status and 00, 10 and 11 mean coefficient. Bits 7:4 have no effect.
- R4: In an address byte, bits 7:4 give the channel (0 to 7 for data channels, 8 for the auxiliary channel) and bits 3:0 give the tap (0 to 11). A byte with either field out of range is discarded and leaves the previous address in place.
- R5: A coefficient write stores the byte at the selected channel and tap when its transfer ends. No other slot changes.
- R6: With coefficient readback, a read puts the two's complement coefficient at the selected slot on the data line, bit 0 first. Bit 0 is present once the enable strobe has risen, and each rising edge of the bit clock moves to the next bit.
- R7: With speed readback, a read shifts out the speed status input as it stood at the start of the read. Its layout is bit 7 invalid flag, bits 6:2 speed count, bits 1:0 speed range, and it passes through unaltered.
- R8: When any read transfer ends, the readback kind returns to coefficient.
- R9: The auxiliary channel's tap 0 always holds zero. A write to it stores zero.
- R10: The data line output enable is high only while a read transfer is in progress and the enable strobe is high.
- R11: A transfer that ends with fewer than eight bits changes nothing. Bit clock edges after the eighth bit are ignored.
- R12: The equalizer read port returns the stored coefficient for the channel and tap presented, and zero for any out-of-range channel or tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Transfer enable strobe from the host |
| host_sclk | input | 1 | Bit clock from the host |
| host_ctl | input | 2 | Exchange control code, latched at transfer start |
| host_din | input | 1 | Data line as seen at the pad input |
| host_dout | output | 1 | Data line value driven during reads |
| host_doe | output | 1 | Data line output enable |
| speed_status | input | 8 | Tape-speed status byte |
| op_mode | output | 2 | Operating mode from the last mode byte |
| eq_rd_chan | input | 4 | Equalizer read port channel |
| eq_rd_tap | input | 4 | Equalizer read port tap |
| eq_rd_coef | output | 8 | Coefficient at the equalizer read address |

## Verification
Random channel and tap pairs, some outside the legal range, are loaded as addresses and followed by random coefficient writes. Each is read back over the serial line and through the equalizer port. This shows whether a store went to the right slot and whether an illegal address really left the previous one in place. Directed transfers cover the cases that random traffic rarely reaches: short and over-long bit counts, which separate a committed byte from a discarded or truncated one, and writes to auxiliary tap 0. A speed read is followed by a second read to show that the readback kind reverts. Mode bytes with their upper bits set show that those bits change nothing.

// File: rtl/eq_port_pkg.sv
package eq_port_pkg;
  typedef enum logic [1:0] {
    CMD_COEF_WR = 2'b00,
    CMD_READ    = 2'b01,
    CMD_ADDR    = 2'b10,
    CMD_MODE    = 2'b11
  } host_cmd_e;

  typedef enum logic [1:0] {
    RB_COEF  = 2'b00,
    RB_SPEED = 2'b01,
    RB_ALT2  = 2'b10,
    RB_ALT3  = 2'b11
  } readback_e;
endpackage

// File: rtl/eq_port_sync.sv
module eq_port_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/eq_port_shifter.sv
module eq_port_shifter #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] load_val,
  input  logic          shift_en,
  input  logic          sdin,
  output logic [DW-1:0] sreg,
  output logic          sdout,
  output logic          full
);
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DW));
  assign sdout = sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (start) begin
      sreg <= load_val;
      cnt  <= '0;
    end else if (shift_en && !full) begin
      sreg <= {sdin, sreg[DW-1:1]};
      cnt  <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/eq_port_coef_ram.sv
module eq_port_coef_ram #(
  parameter int NCH  = 9,
  parameter int NTAP = 12,
  parameter int DW   = 8,
  parameter int CHW  = 4,
  parameter int TPW  = 4,
  localparam int DEPTH = NCH * NTAP,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] wch,
  input  logic [TPW-1:0] wtap,
  input  logic [DW-1:0]  wdata,
  input  logic [CHW-1:0] ra_ch,
  input  logic [TPW-1:0] ra_tap,
  output logic [DW-1:0]  ra_data,
  input  logic [CHW-1:0] rb_ch,
  input  logic [TPW-1:0] rb_tap,
  output logic [DW-1:0]  rb_data
);
  logic [DW-1:0] mem [DEPTH];

  function automatic logic in_range(input logic [CHW-1:0] ch, input logic [TPW-1:0] tp);
    return (int'(ch) < NCH) && (int'(tp) < NTAP);
  endfunction

  function automatic logic [IW-1:0] slot(input logic [CHW-1:0] ch, input logic [TPW-1:0] tp);
    return IW'(int'(ch) * NTAP + int'(tp));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_range(wch, wtap)) begin
      mem[slot(wch, wtap)] <= wdata;
    end
  end

  always_comb begin
    ra_data = in_range(ra_ch, ra_tap) ? mem[slot(ra_ch, ra_tap)] : '0;
    rb_data = in_range(rb_ch, rb_tap) ? mem[slot(rb_ch, rb_tap)] : '0;
  end
endmodule

// File: rtl/eq_coef_serial_port.sv
module eq_coef_serial_port #(
  parameter int NCH  = 9,
  parameter int NTAP = 12,
  parameter int DW   = 8,
  parameter int CHW  = 4,
  parameter int TPW  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_en,
  input  logic           host_sclk,
  input  logic [1:0]     host_ctl,
  input  logic           host_din,
  output logic           host_dout,
  output logic           host_doe,
  input  logic [DW-1:0]  speed_status,
  output logic [1:0]     op_mode,
  input  logic [CHW-1:0] eq_rd_chan,
  input  logic [TPW-1:0] eq_rd_tap,
  output logic [DW-1:0]  eq_rd_coef
);
  import eq_port_pkg::*;

  localparam int SW = 5;
  localparam logic [CHW-1:0] AUX_CH = CHW'(NCH - 1);

  logic [SW-1:0] pins_s;
  logic          en_s, sclk_s, din_s;
  logic [1:0]    ctl_s;
  logic          en_q, sclk_q;
  logic          en_rise, en_fall, sclk_rise;

  eq_port_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_en, host_sclk, host_din, host_ctl}),
    .q(pins_s)
  );
  assign {en_s, sclk_s, din_s, ctl_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      en_q   <= en_s;
      sclk_q <= sclk_s;
    end
  end

  assign en_rise   = en_s & ~en_q;
  assign en_fall   = ~en_s & en_q;
  assign sclk_rise = sclk_s & ~sclk_q;

  host_cmd_e        cmd;
  logic             active;
  readback_e        rb_kind;
  logic [CHW-1:0]   sel_ch;
  logic [TPW-1:0]   sel_tap;
  logic [DW-1:0]    sreg;
  logic             sdout, full;
  logic [DW-1:0]    sel_coef, load_val;
  logic             coef_we;
  logic [DW-1:0]    coef_wdata;
  logic             addr_ok;

  always_comb begin
    if (host_cmd_e'(ctl_s) != CMD_READ) load_val = '0;
    else if (rb_kind == RB_SPEED)       load_val = speed_status;
    else                                load_val = sel_coef;
  end

  eq_port_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(en_rise),
    .load_val(load_val),
    .shift_en(active & en_s & sclk_rise),
    .sdin(din_s),
    .sreg(sreg),
    .sdout(sdout),
    .full(full)
  );

  assign addr_ok = (int'(sreg[DW-1 -: CHW]) < NCH) && (int'(sreg[TPW-1:0]) < NTAP);

  assign coef_we    = en_fall & active & full & (cmd == CMD_COEF_WR);
  assign coef_wdata = (sel_ch == AUX_CH && sel_tap == '0) ? '0 : sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd     <= CMD_COEF_WR;
      active  <= 1'b0;
      rb_kind <= RB_COEF;
      sel_ch  <= '0;
      sel_tap <= '0;
      op_mode <= 2'b00;
    end else if (en_rise) begin
      cmd    <= host_cmd_e'(ctl_s);
      active <= 1'b1;
    end else if (en_fall && active) begin
      active <= 1'b0;
      case (cmd)
        CMD_READ: rb_kind <= RB_COEF;
        CMD_MODE: if (full) begin
          op_mode <= sreg[1:0];
          rb_kind <= readback_e'(sreg[3:2]);
        end
        CMD_ADDR: if (full && addr_ok) begin
          sel_ch  <= sreg[DW-1 -: CHW];
          sel_tap <= sreg[TPW-1:0];
        end
        default: ;
      endcase
    end
  end

  eq_port_coef_ram #(
    .NCH(NCH), .NTAP(NTAP), .DW(DW), .CHW(CHW), .TPW(TPW)
  ) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(coef_we), .wch(sel_ch), .wtap(sel_tap), .wdata(coef_wdata),
    .ra_ch(sel_ch), .ra_tap(sel_tap), .ra_data(sel_coef),
    .rb_ch(eq_rd_chan), .rb_tap(eq_rd_tap), .rb_data(eq_rd_coef)
  );

  assign host_doe  = active & en_s & (cmd == CMD_READ);
  assign host_dout = host_doe & sdout;
endmodule

// File: rtl/eq_coef_serial_port_checker.sv
module eq_coef_serial_port_checker #(
  parameter int NCH  = 9,
  parameter int NTAP = 12,
  parameter int DW   = 8,
  parameter int CHW  = 4,
  parameter int TPW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_s,
  input logic           en_fall,
  input logic           active,
  input logic [1:0]     cmd,
  input logic [1:0]     rb_kind,
  input logic           coef_we,
  input logic           full,
  input logic           host_doe,
  input logic [CHW-1:0] eq_rd_chan,
  input logic [TPW-1:0] eq_rd_tap,
  input logic [DW-1:0]  eq_rd_coef
);
  // R10: output enable only during a read with the strobe high
  a_r10_doe_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> (en_s && active && cmd == 2'b01));

  // R8: readback kind reverts after any read transfer
  a_r8_readback_reverts: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && active && cmd == 2'b01) |=> (rb_kind == 2'b00));

  // R11: no store from a transfer short of eight bits
  a_r11_write_needs_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> full);

  // R5: store only when a transfer ends
  a_r5_write_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> (en_fall && !en_s));

  // R9: auxiliary tap 0 is always zero
  a_r9_aux_tap0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(eq_rd_chan) == NCH - 1 && eq_rd_tap == '0) |-> (eq_rd_coef == '0));

  // R12: out-of-range equalizer reads return zero
  a_r12_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(eq_rd_chan) >= NCH || int'(eq_rd_tap) >= NTAP) |-> (eq_rd_coef == '0));
endmodule

bind eq_coef_serial_port eq_coef_serial_port_checker #(
  .NCH(NCH), .NTAP(NTAP), .DW(DW), .CHW(CHW), .TPW(TPW)
) u_checker (
  .clk(clk), .rst_n(rst_n),
  .en_s(en_s), .en_fall(en_fall), .active(active),
  .cmd(cmd), .rb_kind(rb_kind),
  .coef_we(coef_we), .full(full), .host_doe(host_doe),
  .eq_rd_chan(eq_rd_chan), .eq_rd_tap(eq_rd_tap), .eq_rd_coef(eq_rd_coef)
);

// File: tb/eq_coef_serial_port_bench.sv
module eq_coef_serial_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_en = 1'b0, host_sclk = 1'b0, host_din = 1'b0;
  logic [1:0] host_ctl = 2'b00;
  logic       host_dout, host_doe;
  logic [7:0] speed_status = 8'h00;
  logic [1:0] op_mode;
  logic [3:0] eq_rd_chan = 4'd0, eq_rd_tap = 4'd0;
  logic [7:0] eq_rd_coef;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] ref_mem [9][12];
  int ref_ch = 0, ref_tap = 0;
  int ref_rb = 0;

  always #2 clk = ~clk;

  eq_coef_serial_port u_eq_coef_serial_port (
    .clk(clk), .rst_n(rst_n),
    .host_en(host_en), .host_sclk(host_sclk), .host_ctl(host_ctl), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe),
    .speed_status(speed_status), .op_mode(op_mode),
    .eq_rd_chan(eq_rd_chan), .eq_rd_tap(eq_rd_tap), .eq_rd_coef(eq_rd_coef)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_coef(input int ch, input int tp);
    if (ch > 8 || tp > 11) return 8'h00;
    return ref_mem[ch][tp];
  endfunction

  task automatic xfer_write(input logic [1:0] ctl, input logic [7:0] b, input int nbits);
    logic doe_seen = 1'b0;
    host_ctl = ctl;
    wait_clk(6);
    host_en = 1'b1;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      host_din = b[i % 8];
      wait_clk(4);
      host_sclk = 1'b1;
      wait_clk(6);
      doe_seen |= host_doe;
      host_sclk = 1'b0;
      wait_clk(4);
    end
    host_en = 1'b0;
    wait_clk(8);
    check("R10 doe low during write", {7'd0, doe_seen}, 8'h00);
  endtask

  task automatic xfer_read(output logic [7:0] b);
    logic doe_all = 1'b1;
    host_ctl = 2'b01;
    wait_clk(6);
    host_en = 1'b1;
    wait_clk(6);
    for (int i = 0; i < 8; i++) begin
      b[i] = host_dout;
      doe_all &= host_doe;
      host_sclk = 1'b1;
      wait_clk(6);
      host_sclk = 1'b0;
      wait_clk(4);
    end
    host_en = 1'b0;
    wait_clk(8);
    check("R10 doe high through read", {7'd0, doe_all}, 8'h01);
    check("R10 doe low after read", {7'd0, host_doe}, 8'h00);
    ref_rb = 0;
  endtask

  task automatic set_addr(input int ch, input int tp);
    xfer_write(2'b10, {4'(ch), 4'(tp)}, 8);
    if (ch <= 8 && tp <= 11) begin
      ref_ch = ch;
      ref_tap = tp;
    end
  endtask

  task automatic write_coef(input logic [7:0] v);
    xfer_write(2'b00, v, 8);
    ref_mem[ref_ch][ref_tap] = (ref_ch == 8 && ref_tap == 0) ? 8'h00 : v;
  endtask

  task automatic read_check(input string req);
    logic [7:0] got;
    logic [7:0] exp;
    exp = (ref_rb == 1) ? speed_status : model_coef(ref_ch, ref_tap);
    xfer_read(got);
    check(req, got, exp);
  endtask

  task automatic eq_check(input string req, input int ch, input int tp);
    eq_rd_chan = 4'(ch);
    eq_rd_tap  = 4'(tp);
    wait_clk(1);
    check(req, eq_rd_coef, model_coef(ch, tp));
  endtask

  initial begin
    wait_clk(200000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 9; c++)
      for (int t = 0; t < 12; t++) ref_mem[c][t] = 8'h00;

    wait_clk(5);
    // R1: reset state
    check("R1 doe at reset", {7'd0, host_doe}, 8'h00);
    check("R1 op_mode at reset", {6'd0, op_mode}, 8'h00);
    rst_n = 1'b1;
    wait_clk(4);
    eq_check("R1 coef zero after reset", 3, 7);
    read_check("R1 R6 read at reset address");

    // R2 R3: mode byte, upper bits ignored
    xfer_write(2'b11, 8'hF2, 8);
    check("R3 op_mode from mode byte", {6'd0, op_mode}, 8'h02);
    xfer_write(2'b11, 8'h03, 8);
    check("R3 op_mode other value", {6'd0, op_mode}, 8'h03);

    // R4 R5 R6: directed write and readback
    set_addr(2, 5);
    write_coef(8'hA6);
    read_check("R5 R6 directed readback");
    eq_check("R12 eq port directed", 2, 5);
    eq_check("R5 neighbour untouched", 2, 6);

    // R4: out-of-range address keeps previous
    set_addr(9, 0);
    set_addr(1, 12);
    write_coef(8'h5B);
    read_check("R4 illegal address discarded");
    eq_check("R4 store landed at previous address", 2, 5);

    // R9: auxiliary tap 0
    set_addr(8, 0);
    xfer_write(2'b00, 8'h7F, 8);
    read_check("R9 aux tap0 reads zero");
    set_addr(8, 11);
    write_coef(8'h81);
    read_check("R4 aux last tap writable");

    // R11: short and long transfers
    set_addr(4, 4);
    write_coef(8'h33);
    xfer_write(2'b00, 8'hCC, 5);
    read_check("R11 short write discarded");
    xfer_write(2'b10, 8'h10, 3);
    read_check("R11 short address discarded");
    xfer_write(2'b00, 8'h96, 11);
    ref_mem[4][4] = 8'h96;
    read_check("R11 extra bits ignored");

    // R7 R8: speed readback then revert
    speed_status = 8'b1_01101_10;
    xfer_write(2'b11, 8'h04, 8);
    ref_rb = 1;
    read_check("R7 speed byte readback");
    read_check("R8 reverted to coefficient");
    speed_status = 8'b0_11111_01;
    xfer_write(2'b11, 8'h08, 8);
    read_check("R3 kind 10 is coefficient");
    xfer_write(2'b11, 8'h05, 8);
    ref_rb = 1;
    read_check("R7 second speed byte");
    check("R3 op_mode after speed setup", {6'd0, op_mode}, 8'h01);

    // random traffic
    for (int k = 0; k < 40; k++) begin
      int ch, tp;
      ch = int'($urandom % 10);
      tp = int'($urandom % 13);
      set_addr(ch, tp);
      write_coef(8'($urandom));
      read_check("R5 R6 random readback");
      eq_check("R12 random eq port", int'($urandom % 11), int'($urandom % 14));
    end
    for (int c = 0; c < 9; c++) eq_check("R12 sweep tap 0", c, 0);
    eq_check("R12 out-of-range channel", 12, 3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule